// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Address Sleep Filter

This block takes in characters on a single asynchronous serial line. Each character has 7, 8 or 9 data bits, sent least significant bit first, an optional even or odd parity bit, and one or two stop bits. An external enable tick sets the oversampling rate at 16 times the bit rate. The block finds the falling edge of the start bit and confirms at mid-bit that the line is still low. It then samples every later bit at the centre of its bit period. When a frame is complete, the character moves from the shift register into a receive buffer, and a set of status flags is updated at that same moment.

A host reads the buffer by pulsing a read strobe. An active-low ready-to-send output shows when the receiver can accept a new character. A one-cycle interrupt pulse marks each new arrival. A sleep mode supports multidrop buses: with sleep set, a frame whose most significant data bit is 0 is dropped without any trace, and an address frame (top bit 1) is received as normal. The configuration inputs are captured once per frame, when the start edge is seen.

Top module: `uart_rx_sleep`

## Requirements
- R1: While `rxEnable` is 0, `rtsN` is 1. While `rxEnable` is 1 and no frame is in progress, `rtsN` is 0.
- R2: `rtsN` goes to 1 once a start edge is detected. It stays 1 until the frame is finished or rejected, and then returns to 0.
- R3: A start bit that reads 1 at its mid-point (the 8th tick after the falling edge) is treated as a glitch. It changes no flag, no data and no interrupt, and the receiver goes back to waiting for a start edge.
- R4: Data bits are taken LSB first. `cfgLen` 0 selects 7 bits, 1 selects 8 bits, and 2 or 3 selects 9 bits. The character appears right-aligned on `rxData[8:0]` with the unused upper bits at 0.
- R5: When `cfgParityEn` is 1, one parity bit follows the data. `cfgParityOdd` 0 means the data bits and the parity bit together hold an even number of ones; 1 means an odd number. `parityErr` is loaded with the mismatch result of each accepted frame. It is 0 when parity is off.
- R6: `cfgTwoStop` selects two stop bits instead of one. `frameErr` is loaded with 1 for an accepted frame in which any expected stop bit is sampled as 0, and with 0 otherwise.
- R7: An accepted frame sets `rxReady`. `overrunErr` sets if a frame is accepted while `rxReady` is already 1.
- R8: A one-cycle pulse on `rdStrobe` clears `rxReady`, `frameErr` and `parityErr`. It does not clear `overrunErr` or `errSummary`.
- R9: `errSummary` sets whenever overrun, framing error or parity error is raised. It is cleared only by taking `rxEnable` to 0.
- R10: `irq` is high for exactly one cycle each time `rxReady` changes from 0 to 1.
- R11: Taking `rxEnable` to 0 clears every flag and abandons any frame in progress.
- R12: With `cfgSleep` set, a frame whose top data bit (bit 6, 7 or 8 for 7, 8 or 9 bits) is 0 leaves the buffer, all flags and `irq` unchanged. A frame with that bit at 1 is received normally.
- R13: Configuration inputs are captured at the start edge. Changing them during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxEnable | input | 1 | Receiver enable; 0 clears flags |
| baudTick | input | 1 | Oversample enable, 16 per bit |
| rxd | input | 1 | Serial data line |
| cfgLen | input | 2 | Character length select |
| cfgParityEn | input | 1 | Parity bit present |
| cfgParityOdd | input | 1 | Odd parity when 1 |
| cfgTwoStop | input | 1 | Two stop bits when 1 |
| cfgSleep | input | 1 | Sleep filter enable |
| rdStrobe | input | 1 | Buffer read pulse |
| rxData | output | 9 | Receive buffer |
| rxReady | output | 1 | Buffer holds unread data |
| overrunErr | output | 1 | Sticky overrun flag |
| frameErr | output | 1 | Stop-bit error flag |
| parityErr | output | 1 | Parity mismatch flag |
| errSummary | output | 1 | Sticky any-error flag |
| rtsN | output | 1 | Active-low ready to receive |
| irq | output | 1 | One-cycle arrival pulse |

## Verification
The checker module watches five properties on every cycle:
- `irq` matches exactly the rising edges of `rxReady`.
- `overrunErr` is sticky while the receiver stays enabled.
- `errSummary` covers every error flag.
- Disabling the receiver clears all flags.
- `rtsN` is never low while the receiver is disabled.

Only the bench scenarios can show the rest:
- the captured character value and its alignment for each length;
- the parity and stop-bit decisions;
- glitch rejection of a false start bit;
- frames dropped by the sleep filter;
- immunity to configuration changes in mid-frame.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int MAX_BITS = 9;

  typedef enum logic [1:0] {LEN7 = 2'd0, LEN8 = 2'd1, LEN9 = 2'd2, LEN9B = 2'd3} charLen_e;

  typedef struct packed {
    charLen_e len;
    logic     parityEn;
    logic     parityOdd;
    logic     twoStop;
    logic     sleep;
  } rxCfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic frameStart;
    logic shiftBit;
    logic checkParity;
    logic frameDone;
    logic stopBad;
    logic bitVal;
  } rxStrobe_t;

  function automatic logic [3:0] lenBits(charLen_e l);
    case (l)
      LEN7:    return 4'd7;
      LEN8:    return 4'd8;
      default: return 4'd9;
    endcase
  endfunction
endpackage

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      rxEnable,
  input  logic      baudTick,
  input  logic      rxd,
  input  rxCfg_t    cfgIn,
  output rxCfg_t    cfgOut,
  output rxStrobe_t strobe,
  output logic      rtsN
);
  localparam int CW   = $clog2(OSR);
  localparam int HALF = OSR / 2;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PARITY, S_STOP1, S_STOP2} rxState_e;

  rxState_e state;
  logic [CW-1:0] tickCnt;
  logic [3:0] bitCnt;
  logic rxMeta, rxSync, rxPrev;
  rxCfg_t cfgQ;

  logic startEdge, bitEnd, sampleNow, moreStop;
  logic [3:0] lastBit;

  assign startEdge = rxPrev && !rxSync;
  assign bitEnd    = baudTick && (tickCnt == CW'(OSR - 1));
  assign sampleNow = rxEnable && bitEnd && (state != S_IDLE) && (state != S_START);
  assign lastBit   = lenBits(cfgQ.len) - 4'd1;
  assign moreStop  = cfgQ.twoStop && rxSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMeta  <= 1'b1;
      rxSync  <= 1'b1;
      rxPrev  <= 1'b1;
      state   <= S_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
      cfgQ    <= '0;
    end else begin
      rxMeta <= rxd;
      rxSync <= rxMeta;
      rxPrev <= rxSync;
      if (!rxEnable) begin
        state <= S_IDLE;
      end else begin
        case (state)
          S_IDLE: if (startEdge) begin
            state   <= S_START;
            tickCnt <= '0;
            cfgQ    <= cfgIn;
          end
          S_START: if (baudTick) begin
            if (tickCnt == CW'(HALF - 1)) begin
              tickCnt <= '0;
              bitCnt  <= '0;
              state   <= rxSync ? S_IDLE : S_DATA;
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
          default: if (baudTick) begin
            if (bitEnd) begin
              tickCnt <= '0;
              case (state)
                S_DATA: begin
                  bitCnt <= bitCnt + 4'd1;
                  if (bitCnt == lastBit) state <= cfgQ.parityEn ? S_PARITY : S_STOP1;
                end
                S_PARITY: state <= S_STOP1;
                S_STOP1:  state <= moreStop ? S_STOP2 : S_IDLE;
                default:  state <= S_IDLE;
              endcase
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
        endcase
      end
    end
  end

  always_comb begin
    strobe.frameStart  = rxEnable && (state == S_IDLE) && startEdge;
    strobe.shiftBit    = sampleNow && (state == S_DATA);
    strobe.checkParity = sampleNow && (state == S_PARITY);
    strobe.frameDone   = sampleNow && ((state == S_STOP2) || ((state == S_STOP1) && !moreStop));
    strobe.stopBad     = !rxSync;
    strobe.bitVal      = rxSync;
  end

  assign cfgOut = cfgQ;
  assign rtsN   = !(rxEnable && (state == S_IDLE));
endmodule

// File: rtl/uart_rx_dp.sv
module uart_rx_dp
  import uart_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                rxEnable,
  input  logic                rdStrobe,
  input  charLen_e            len,
  input  logic                parityEn,
  input  logic                parityOdd,
  input  logic                sleep,
  input  rxStrobe_t           strobe,
  output logic [MAX_BITS-1:0] rxData,
  output logic                rxReady,
  output logic                overrunErr,
  output logic                frameErr,
  output logic                parityErr,
  output logic                errSummary,
  output logic                irq
);
  logic [MAX_BITS-1:0] shiftReg, aligned;
  logic parAcc, parBad, accept, newPe;

  // after n shifts the top data bit always sits in the MSB
  assign aligned = shiftReg >> (4'(MAX_BITS) - lenBits(len));
  assign accept  = strobe.frameDone && !(sleep && !shiftReg[MAX_BITS-1]);
  assign newPe   = parBad && parityEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parAcc   <= 1'b0;
      parBad   <= 1'b0;
    end else if (strobe.frameStart) begin
      shiftReg <= '0;
      parAcc   <= 1'b0;
      parBad   <= 1'b0;
    end else if (strobe.shiftBit) begin
      shiftReg <= {strobe.bitVal, shiftReg[MAX_BITS-1:1]};
      parAcc   <= parAcc ^ strobe.bitVal;
    end else if (strobe.checkParity) begin
      parBad <= (parAcc ^ strobe.bitVal) != parityOdd;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData     <= '0;
      rxReady    <= 1'b0;
      overrunErr <= 1'b0;
      frameErr   <= 1'b0;
      parityErr  <= 1'b0;
      errSummary <= 1'b0;
      irq        <= 1'b0;
    end else if (!rxEnable) begin
      rxReady    <= 1'b0;
      overrunErr <= 1'b0;
      frameErr   <= 1'b0;
      parityErr  <= 1'b0;
      errSummary <= 1'b0;
      irq        <= 1'b0;
    end else if (accept) begin
      rxData     <= aligned;
      rxReady    <= 1'b1;
      overrunErr <= overrunErr | rxReady;
      frameErr   <= strobe.stopBad;
      parityErr  <= newPe;
      errSummary <= errSummary | rxReady | strobe.stopBad | newPe;
      irq        <= !rxReady;
    end else begin
      irq <= 1'b0;
      if (rdStrobe) begin
        rxReady   <= 1'b0;
        frameErr  <= 1'b0;
        parityErr <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uart_rx_sleep.sv
module uart_rx_sleep
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxEnable,
  input  logic       baudTick,
  input  logic       rxd,
  input  logic [1:0] cfgLen,
  input  logic       cfgParityEn,
  input  logic       cfgParityOdd,
  input  logic       cfgTwoStop,
  input  logic       cfgSleep,
  input  logic       rdStrobe,
  output logic [8:0] rxData,
  output logic       rxReady,
  output logic       overrunErr,
  output logic       frameErr,
  output logic       parityErr,
  output logic       errSummary,
  output logic       rtsN,
  output logic       irq
);
  rxCfg_t cfgIn, cfgQ;
  rxStrobe_t strobe;

  assign cfgIn = '{len: charLen_e'(cfgLen), parityEn: cfgParityEn, parityOdd: cfgParityOdd,
                   twoStop: cfgTwoStop, sleep: cfgSleep};

  uart_rx_ctrl #(.OSR(OSR)) u_ctrl (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .baudTick(baudTick), .rxd(rxd),
    .cfgIn(cfgIn), .cfgOut(cfgQ), .strobe(strobe), .rtsN(rtsN)
  );

  uart_rx_dp u_dp (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .rdStrobe(rdStrobe),
    .len(cfgQ.len), .parityEn(cfgQ.parityEn), .parityOdd(cfgQ.parityOdd), .sleep(cfgQ.sleep),
    .strobe(strobe), .rxData(rxData), .rxReady(rxReady), .overrunErr(overrunErr),
    .frameErr(frameErr), .parityErr(parityErr), .errSummary(errSummary), .irq(irq)
  );
endmodule

// File: rtl/uart_rx_sleep_chk.sv
module uart_rx_sleep_chk (
  input logic clk,
  input logic rstN,
  input logic rxEnable,
  input logic rxReady,
  input logic overrunErr,
  input logic frameErr,
  input logic parityErr,
  input logic errSummary,
  input logic rtsN,
  input logic irq
);
  assert_irq_on_rise_R10: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (rxReady && !$past(rxReady)));

  assert_rise_gives_irq_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxReady) |-> irq);

  assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rxEnable) && $past(overrunErr)) |-> overrunErr);

  assert_summary_covers_R9: assert property (@(posedge clk) disable iff (!rstN)
    (overrunErr || frameErr || parityErr) |-> errSummary);

  assert_disable_clears_R11: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rxEnable) |-> !(rxReady || overrunErr || frameErr || parityErr || errSummary || irq));

  assert_rts_needs_enable_R1: assert property (@(posedge clk) disable iff (!rstN)
    !rtsN |-> rxEnable);
endmodule

bind uart_rx_sleep uart_rx_sleep_chk u_chk (
  .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .rxReady(rxReady),
  .overrunErr(overrunErr), .frameErr(frameErr), .parityErr(parityErr),
  .errSummary(errSummary), .rtsN(rtsN), .irq(irq)
);

// File: tb/uart_rx_sleep_tb.sv
module uart_rx_sleep_tb;
  logic clk = 1'b0, rstN = 1'b0, rxEnable = 1'b0, baudTick = 1'b1, rxd = 1'b1;
  logic [1:0] cfgLen = 2'd1;
  logic cfgParityEn = 1'b0, cfgParityOdd = 1'b0, cfgTwoStop = 1'b0, cfgSleep = 1'b0, rdStrobe = 1'b0;
  logic [8:0] rxData;
  logic rxReady, overrunErr, frameErr, parityErr, errSummary, rtsN, irq;

  int checks = 0, fails = 0, irqCount = 0;
  bit finished = 1'b0, prevIrq = 1'b0;
  logic [8:0] expData = '0;
  bit expReady = 0, expOvr = 0, expFe = 0, expPe = 0, expSum = 0;
  int expIrq = 0;

  always #10 clk = ~clk;

  uart_rx_sleep u_dut (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .baudTick(baudTick), .rxd(rxd),
    .cfgLen(cfgLen), .cfgParityEn(cfgParityEn), .cfgParityOdd(cfgParityOdd),
    .cfgTwoStop(cfgTwoStop), .cfgSleep(cfgSleep), .rdStrobe(rdStrobe),
    .rxData(rxData), .rxReady(rxReady), .overrunErr(overrunErr), .frameErr(frameErr),
    .parityErr(parityErr), .errSummary(errSummary), .rtsN(rtsN), .irq(irq)
  );

  always @(negedge clk) begin
    if (irq) irqCount++;
    if (irq && prevIrq) begin
      fails++;
      $display("FAIL R10 irq width: actual >1 cycle expected 1 cycle");
    end
    prevIrq = irq;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    check({tag, " R4 data"}, rxData, expData);
    check({tag, " R7 ready"}, rxReady, expReady);
    check({tag, " R7 overrun"}, overrunErr, expOvr);
    check({tag, " R6 frame"}, frameErr, expFe);
    check({tag, " R5 parity"}, parityErr, expPe);
    check({tag, " R9 summary"}, errSummary, expSum);
    check({tag, " R10 irq count"}, irqCount, expIrq);
    check({tag, " R2 rts idle"}, rtsN, 0);
  endtask

  task automatic driveBit(logic b);
    rxd = b;
    repeat (16) @(negedge clk);
  endtask

  task automatic readBuf();
    @(negedge clk) rdStrobe = 1'b1;
    @(negedge clk) rdStrobe = 1'b0;
    expReady = 0; expFe = 0; expPe = 0;
  endtask

  task automatic clearAll();
    @(negedge clk) rxEnable = 1'b0;
    @(negedge clk);
    check("R1 rts disabled", rtsN, 1);
    rxEnable = 1'b1;
    expReady = 0; expOvr = 0; expFe = 0; expPe = 0; expSum = 0;
    @(negedge clk);
  endtask

  // badStop: 0 none, 1 first stop low, 2 second stop low
  task automatic sendFrame(logic [8:0] data, int lenSel, bit pEn, bit odd, bit two, bit slp,
                           int badStop, bit badPar);
    int n = (lenSel == 0) ? 7 : (lenSel == 1) ? 8 : 9;
    logic [8:0] masked = data & 9'((1 << n) - 1);
    bit pBit = (^masked) ^ odd ^ badPar;
    bit top = masked[n-1];
    cfgLen = 2'(lenSel); cfgParityEn = pEn; cfgParityOdd = odd; cfgTwoStop = two; cfgSleep = slp;
    @(negedge clk);
    driveBit(1'b0);
    check("R2 rts busy", rtsN, 1);
    // R13: scramble configuration mid-frame
    cfgLen = 2'($urandom_range(0, 3)); cfgParityEn = 1'($urandom); cfgParityOdd = 1'($urandom);
    cfgTwoStop = 1'($urandom); cfgSleep = 1'($urandom);
    for (int i = 0; i < n; i++) driveBit(masked[i]);
    if (pEn) driveBit(pBit);
    driveBit(badStop == 1 ? 1'b0 : 1'b1);
    if (two) driveBit(badStop == 2 ? 1'b0 : 1'b1);
    rxd = 1'b1;
    repeat (24) @(negedge clk);
    if (!(slp && !top)) begin
      if (!expReady) expIrq++;
      expOvr = expOvr | expReady;
      expFe = (badStop != 0);
      expPe = pEn && badPar;
      expSum = expSum | expReady | expFe | expPe;
      expReady = 1;
      expData = masked;
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset rts", rtsN, 1);
    check("R7 reset ready", rxReady, 0);
    check("R10 reset irq", irq, 0);
    rxEnable = 1'b1;
    @(negedge clk);
    check("R1 rts enabled", rtsN, 0);

    sendFrame(9'h0A5, 1, 0, 0, 0, 0, 0, 0); checkAll("8bit");
    readBuf(); checkAll("R8 read");
    sendFrame(9'h17F, 0, 1, 0, 0, 0, 0, 0); checkAll("7bit even");
    sendFrame(9'h1C3, 2, 1, 1, 1, 0, 0, 0); checkAll("9bit odd overrun");
    readBuf(); checkAll("R8 keeps overrun");
    sendFrame(9'h055, 1, 1, 0, 0, 0, 0, 1); checkAll("R5 bad parity");
    readBuf();
    sendFrame(9'h033, 1, 0, 0, 1, 0, 2, 0); checkAll("R6 second stop");
    clearAll(); checkAll("R11 cleared");

    // R3 glitch
    rxd = 1'b0; repeat (4) @(negedge clk); rxd = 1'b1;
    repeat (30) @(negedge clk);
    checkAll("R3 glitch");

    // R12 sleep filter
    sendFrame(9'h012, 1, 0, 0, 0, 1, 0, 0); checkAll("R12 dropped");
    sendFrame(9'h092, 1, 0, 0, 0, 1, 0, 0); checkAll("R12 address");
    readBuf();
    sendFrame(9'h03F, 0, 0, 0, 0, 1, 1, 0); checkAll("R12 dropped 7bit");

    // R11 abort mid-frame
    cfgSleep = 1'b0;
    @(negedge clk) rxd = 1'b0;
    repeat (40) @(negedge clk);
    rxEnable = 1'b0;
    @(negedge clk) rxd = 1'b1;
    repeat (200) @(negedge clk);
    rxEnable = 1'b1;
    expReady = 0; expOvr = 0; expFe = 0; expPe = 0; expSum = 0;
    repeat (4) @(negedge clk);
    checkAll("R11 abort");

    for (int k = 0; k < 40; k++) begin
      int ls = $urandom_range(0, 2);
      bit two = 1'($urandom);
      int bs = ($urandom_range(0, 6) == 0) ? (two ? $urandom_range(1, 2) : 1) : 0;
      if ($urandom_range(0, 1) == 1) readBuf();
      if ($urandom_range(0, 9) == 0) clearAll();
      sendFrame(9'($urandom), ls, 1'($urandom), 1'($urandom), two,
                ($urandom_range(0, 3) == 0), bs, ($urandom_range(0, 6) == 0));
      checkAll("R13 random");
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule